// File: doc/BRIEF.md
# Header Soft-Bit Pair Combiner

This block sits behind the frame demultiplexer of a satellite receiver and turns the 64 signalling symbols at the head of each physical-layer frame into 32 soft bits for a maximum-likelihood header decoder. The incoming symbols are complex samples that the frame synchronizer has already separated from the data. A valid strobe qualifies each sample. A start marker flags the first header symbol, and a pilot flag states whether the frame carries pilot blocks.

The symbols pass through three registered stages. The first stage removes a fixed plus/minus-one scrambling pattern, chosen bit by bit from a parameter according to the symbol's position in the header. The second stage turns each symbol into a signed soft bit, using the pi/2-BPSK rotation that belongs to its even or odd slot. When the frame has pilots, this stage also negates the soft bits in odd slots. The third stage averages each even soft bit with the odd one that follows it, so every pair yields one soft value.

The output is a stream of combined soft bits with a valid strobe and a last flag that marks the end of each header.

Top module: `plsc_pair_combiner`

## Requirements
- R1: After reset, out_valid and out_last are low and the header position is zero, so the first accepted symbol counts as position 0 even without a start marker. The pilot setting after reset is "no pilots".
- R2: A symbol accepted at position p (0..63) is negated, in both I and Q, when bit p of the SCRAMBLE parameter is 1 (bit 0 is the LSB). It passes unchanged when that bit is 0.
- R3: The soft bit of a descrambled symbol (I,Q) is I+Q at even positions and Q-I at odd positions.
- R4: When the pilot setting of the header is 1, the soft bit at every odd position is negated. When it is 0, odd soft bits are used unchanged. Even soft bits are never negated.
- R5: Each output equals floor((even + odd)/2), where even and odd are the soft bits of positions 2k and 2k+1. This is an arithmetic right shift by one of the pair sum.
- R6: Exactly one output is produced per even/odd pair, so a 64-symbol header yields 32 outputs. out_valid is never high on two consecutive cycles.
- R7: out_last is high together with the output formed from positions 62 and 63, and at no other time.
- R8: A valid symbol with in_sof high is taken as position 0, even in the middle of a header.
- R9: The pilot setting is sampled from in_pilot on the valid symbol that carries in_sof. Changes to in_pilot on the other symbols of the header have no effect.
- R10: Cycles with in_valid low do not advance the position and do not change the outputs that follow. in_sof, in_pilot and the sample values are ignored on such cycles.
- R11: The output for a pair appears two clock cycles after the cycle in which its odd symbol is accepted.
- R12: Full-scale inputs, including -2^(SYM_W-1) on both rails, give exact results with no wrap-around. Outputs are SYM_W+2 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header symbol strobe |
| in_sof | input | 1 | Marks the first symbol of a header |
| in_pilot | input | 1 | Pilot presence for the header, sampled with in_sof |
| in_i | input | SYM_W | In-phase sample, two's complement |
| in_q | input | SYM_W | Quadrature sample, two's complement |
| out_valid | output | 1 | Combined soft bit strobe |
| out_soft | output | SYM_W+2 | Combined soft bit, two's complement |
| out_last | output | 1 | High with the 32nd combined soft bit of a header |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Full-scale negative samples: a design that descrambles or sums at sample width would wrap these into wrong-signed soft values.
- The same data with and without pilots: this catches a flip applied to the wrong parity or not applied at all.
- Odd pair sums: these expose rounding toward zero in place of the arithmetic shift.
- A start marker in the middle of a header: this catches a counter that is not restarted, which would misplace the scrambling bits and the last flag.
- A pilot flag toggled inside a header: a block that follows the live flag would then flip only some of the pairs.
- Gaps in the valid strobe: a counter that runs on idle cycles would desynchronize every later pair.
- A single isolated pair: this pins the two-cycle latency.

// File: rtl/plsc_pkg.sv
package plsc_pkg;
  localparam logic [63:0] DEFAULT_SCRAMBLE = 64'hB4C3_2F17_9A06_E58D;

  function automatic int unsigned pos_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/plsc_descramble.sv
module plsc_descramble #(
  parameter int SYM_W = 16,
  parameter int NSYM  = 64,
  parameter logic [NSYM-1:0] SCRAMBLE = plsc_pkg::DEFAULT_SCRAMBLE[NSYM-1:0]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_pilot,
  input  logic [SYM_W-1:0]   in_i,
  input  logic [SYM_W-1:0]   in_q,
  output logic               d_valid,
  output logic [SYM_W:0]     d_i,
  output logic [SYM_W:0]     d_q,
  output logic               d_odd,
  output logic               d_last,
  output logic               d_pilot
);
  localparam int POS_W = plsc_pkg::pos_bits(NSYM);
  localparam logic [POS_W-1:0] POS_END = POS_W'(NSYM - 1);

  logic [POS_W-1:0] pos_cnt, pos_use;
  logic             pilot_q, pilot_use;
  logic [SYM_W:0]   ext_i, ext_q;

  always_comb begin
    pos_use   = in_sof ? '0 : pos_cnt;
    pilot_use = in_sof ? in_pilot : pilot_q;
    ext_i     = {in_i[SYM_W-1], in_i};
    ext_q     = {in_q[SYM_W-1], in_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_cnt <= '0;
      pilot_q <= 1'b0;
      d_valid <= 1'b0;
      d_i     <= '0;
      d_q     <= '0;
      d_odd   <= 1'b0;
      d_last  <= 1'b0;
      d_pilot <= 1'b0;
    end else begin
      d_valid <= in_valid;
      if (in_valid) begin
        pos_cnt <= (pos_use == POS_END) ? '0 : pos_use + POS_W'(1);
        pilot_q <= pilot_use;
        d_i     <= SCRAMBLE[pos_use] ? -ext_i : ext_i;
        d_q     <= SCRAMBLE[pos_use] ? -ext_q : ext_q;
        d_odd   <= pos_use[0];
        d_last  <= (pos_use == POS_END);
        d_pilot <= pilot_use;
      end
    end
  end

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (pos_cnt == POS_W'(1)));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos_cnt));
  p_pilot_held_r9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_sof) |=> $stable(pilot_q));
endmodule

// File: rtl/plsc_soft_demod.sv
module plsc_soft_demod #(
  parameter int SYM_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               d_valid,
  input  logic [SYM_W:0]     d_i,
  input  logic [SYM_W:0]     d_q,
  input  logic               d_odd,
  input  logic               d_last,
  input  logic               d_pilot,
  output logic               s_valid,
  output logic [SYM_W+1:0]   s_soft,
  output logic               s_odd,
  output logic               s_last
);
  localparam int SW = SYM_W + 2;
  localparam logic signed [SW-1:0] LIM = SW'(1) <<< SYM_W;

  logic signed [SW-1:0] xi, xq, rot, soft_nx;

  always_comb begin
    xi      = SW'($signed(d_i));
    xq      = SW'($signed(d_q));
    rot     = d_odd ? (xq - xi) : (xi + xq);
    soft_nx = (d_pilot && d_odd) ? -rot : rot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_soft  <= '0;
      s_odd   <= 1'b0;
      s_last  <= 1'b0;
    end else begin
      s_valid <= d_valid;
      if (d_valid) begin
        s_soft <= soft_nx;
        s_odd  <= d_odd;
        s_last <= d_last;
      end
    end
  end

  p_soft_range_r12: assert property (@(posedge clk) disable iff (rst)
    s_valid |-> ($signed(s_soft) <= LIM && $signed(s_soft) >= -LIM));
  p_last_is_odd_r7: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_last) |-> s_odd);
endmodule

// File: rtl/plsc_pair_avg.sv
module plsc_pair_avg #(
  parameter int SW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [SW-1:0] s_soft,
  input  logic          s_odd,
  input  logic          s_last,
  output logic          out_valid,
  output logic [SW-1:0] out_soft,
  output logic          out_last
);
  logic [SW-1:0] even_q;
  logic [SW:0]   pair_sum;

  always_comb
    pair_sum = {even_q[SW-1], even_q} + {s_soft[SW-1], s_soft};

  always_ff @(posedge clk) begin
    if (rst) begin
      even_q    <= '0;
      out_valid <= 1'b0;
      out_soft  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= s_valid && s_odd;
      out_last  <= s_valid && s_odd && s_last;
      if (s_valid && !s_odd) even_q <= s_soft;
      if (s_valid && s_odd)  out_soft <= pair_sum[SW:1];
    end
  end

  p_one_per_pair_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

// File: rtl/plsc_pair_combiner.sv
module plsc_pair_combiner #(
  parameter int SYM_W = 16,
  parameter int NSYM  = 64,
  parameter logic [NSYM-1:0] SCRAMBLE = plsc_pkg::DEFAULT_SCRAMBLE[NSYM-1:0]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_pilot,
  input  logic [SYM_W-1:0]   in_i,
  input  logic [SYM_W-1:0]   in_q,
  output logic               out_valid,
  output logic [SYM_W+1:0]   out_soft,
  output logic               out_last
);
  localparam int SW = SYM_W + 2;

  logic             d_valid, d_odd, d_last, d_pilot;
  logic [SYM_W:0]   d_i, d_q;
  logic             s_valid, s_odd, s_last;
  logic [SW-1:0]    s_soft;

  plsc_descramble #(.SYM_W(SYM_W), .NSYM(NSYM), .SCRAMBLE(SCRAMBLE)) u_desc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_pilot(in_pilot), .in_i(in_i), .in_q(in_q),
    .d_valid(d_valid), .d_i(d_i), .d_q(d_q), .d_odd(d_odd),
    .d_last(d_last), .d_pilot(d_pilot));

  plsc_soft_demod #(.SYM_W(SYM_W)) u_demod (
    .clk(clk), .rst(rst), .d_valid(d_valid), .d_i(d_i), .d_q(d_q),
    .d_odd(d_odd), .d_last(d_last), .d_pilot(d_pilot),
    .s_valid(s_valid), .s_soft(s_soft), .s_odd(s_odd), .s_last(s_last));

  plsc_pair_avg #(.SW(SW)) u_avg (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_soft(s_soft),
    .s_odd(s_odd), .s_last(s_last),
    .out_valid(out_valid), .out_soft(out_soft), .out_last(out_last));

  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_odd) |=> out_valid);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_last));
endmodule

// File: tb/tb_plsc_pair_combiner.sv
module tb_plsc_pair_combiner;
  localparam int SYM_W = 16;
  localparam int NSYM  = 64;
  localparam logic [63:0] SCR = 64'hB4C3_2F17_9A06_E58D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_pilot = 1'b0;
  logic [SYM_W-1:0] in_i = '0, in_q = '0;
  logic out_valid, out_last;
  logic [SYM_W+1:0] out_soft;

  always #4 clk = ~clk;

  plsc_pair_combiner #(.SYM_W(SYM_W), .NSYM(NSYM), .SCRAMBLE(SCR)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_pilot(in_pilot), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_soft(out_soft), .out_last(out_last));

  int total = 0, bad = 0;
  int exp_val [0:2047];
  bit exp_lst [0:2047];
  string exp_tag [0:2047];
  int wr = 0, rd = 0;
  int m_pos = 0, m_even = 0;
  bit m_pil = 0;
  bit done = 0;

  // frames: pilot, i0, q0, i step, q step
  localparam int NTBL = 6;
  localparam int TBL [NTBL][5] = '{
    '{0,   1000, -2000,   37,    91},
    '{1,   1000, -2000,   37,    91},
    '{0, -32768, -32768,   0,     0},
    '{1,  32767, -32768,   0,     0},
    '{1,      5,      7, 1031, -2049},
    '{0,  32767,  32767,   0,     0}};

  function automatic int to_s16(input int v);
    logic signed [15:0] t;
    t = 16'(v);
    return int'(t);
  endfunction

  function automatic int ref_soft(input int i, input int q, input int pos, input bit pil);
    int di, dq, s;
    di = SCR[pos] ? -i : i;
    dq = SCR[pos] ? -q : q;
    s  = (pos % 2 == 1) ? dq - di : di + dq;
    if (pil && pos % 2 == 1) s = -s;
    return s;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic drive(input int i, input int q, input bit sof, input bit pil,
                       input bit v, input string tag);
    int s;
    @(posedge clk); #1;
    in_valid = v; in_sof = sof; in_pilot = pil;
    in_i = 16'(i); in_q = 16'(q);
    if (v) begin
      if (sof) begin m_pos = 0; m_pil = pil; end
      s = ref_soft(to_s16(i), to_s16(q), m_pos, m_pil);
      if (m_pos % 2 == 0) m_even = s;
      else begin
        exp_val[wr] = (m_even + s) >>> 1;
        exp_lst[wr] = (m_pos == NSYM - 1);
        exp_tag[wr] = tag;
        wr++;
      end
      m_pos = (m_pos + 1) % NSYM;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(12345, -777, 1'b1, 1'b1, 1'b0, "R10");
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (!out_valid) begin
        if (out_last) chk(1'b0, "R7 last without valid", 1, 0);
      end else if (rd >= wr) begin
        chk(1'b0, "R6 unexpected output", rd, wr);
      end else begin
        chk($signed(out_soft) == exp_val[rd],
            {exp_tag[rd], " R2 R3 R4 R5 soft value"}, $signed(out_soft), exp_val[rd]);
        chk(out_last == exp_lst[rd], {exp_tag[rd], " R7 last flag"}, out_last, exp_lst[rd]);
        rd++;
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(out_last == 0, "R1 reset out_last", out_last, 0);

    // table-driven frames
    for (int f = 0; f < NTBL; f++)
      for (int k = 0; k < NSYM; k++)
        drive(TBL[f][1] + k * TBL[f][3], TBL[f][2] + k * TBL[f][4],
              k == 0, TBL[f][0] != 0, 1'b1, "R12 table");
    idle(4);

    // R11 latency on an isolated pair
    drive(300, -100, 1'b1, 1'b0, 1'b1, "R11");
    drive(-50, 700, 1'b0, 1'b0, 1'b1, "R11");
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk); chk(out_valid == 0, "R11 early output", out_valid, 0);
    @(negedge clk); chk(out_valid == 0, "R11 early output", out_valid, 0);
    @(negedge clk); chk(out_valid == 1, "R11 output at two cycles", out_valid, 1);
    idle(2);

    // R8 restart in mid header
    for (int k = 0; k < 21; k++) drive(k * 500 - 4000, 3000 - k * 211, k == 0, 1'b1, 1'b1, "R8");
    for (int k = 0; k < NSYM; k++) drive(k * 333 - 9000, k * 77, k == 0, 1'b0, 1'b1, "R8");
    idle(4);

    // R9 pilot toggled inside header
    for (int k = 0; k < NSYM; k++) drive(2000 - k * 50, -1500 + k * 91, k == 0, (k == 0) || (k % 3 == 0), 1'b1, "R9");
    idle(4);

    // R10 gaps between symbols
    for (int k = 0; k < NSYM; k++) begin
      drive(k * 401 - 12000, 6000 - k * 199, k == 0, 1'b1, 1'b1, "R10");
      if (k % 3 == 1) idle(k % 4 + 1);
    end
    idle(4);

    // R1 reset mid-stream, then a header with no start marker
    for (int k = 0; k < 20; k++) drive(k * 10, k * 20, k == 0, 1'b1, 1'b1, "R1");
    idle(4);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    m_pos = 0; m_pil = 0;
    @(negedge clk);
    chk(out_valid == 0 && out_last == 0, "R1 outputs after reset", out_valid, 0);
    for (int k = 0; k < NSYM; k++) drive(-k * 600 + 7000, k * 450 - 8000, 1'b0, 1'b1, 1'b1, "R1");
    idle(6);

    chk(rd == wr, "R6 all expected outputs seen", rd, wr);
    chk(wr == NTBL * 32 + 1 + 10 + 32 + 32 + 32 + 10 + 32, "R6 pair count", wr,
        NTBL * 32 + 1 + 10 + 32 + 32 + 32 + 10 + 32);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule